// File: doc/BRIEF.md
# SDRAM Burst Beat Sequencer

This block sits on the data side of an SDRAM controller or memory model. For every read or write column command it works out the column address of each beat of the burst and the cycle in which that beat moves. Write beats are enabled in the cycle they are issued, starting with the command cycle itself. Read beats are fetched at issue and then driven on the data bus a programmable number of cycles (the CAS latency) later. A per-cycle byte-mask input (DQM) suppresses beats. It suppresses write beats in the same cycle and read output two cycles after it is sampled.

Burst length and CAS latency come from a mode-load input and stay fixed until the next load. Column addresses wrap inside the aligned block whose size is the burst length. In full-page mode they wrap around the whole row with no end. A burst in progress is cut short by a new read or write to any bank, by a precharge to the bank being accessed, or, in full-page mode only, by a burst-stop command. Bank timing and the storage array belong to other blocks.

Top module: `sdram_burst_seq`

## Requirements
- R1: On a cycle with `mode_load` high, the burst length is captured from `mode_bl`: codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, code 7 gives full page, and codes 4 to 6 give 1 beat. The CAS latency is captured from `mode_cl` (values 1 to 3, with 0 taken as 1). Both hold while `mode_load` is low. After reset they are 1 beat and CAS latency 2.
- R2: Beat k of a burst of length BL that starts at column S is issued on `beat_col` with the upper bits of S unchanged and the low log2(BL) bits equal to (S + k) mod BL. A burst that runs to the end has exactly BL beats, on consecutive cycles starting with the command cycle.
- R3: For a write, `wr_en` is high in every cycle in which a write beat is issued, beginning with the command cycle. In a cycle where `dqm` is high, `wr_en` stays low but that beat is still used up.
- R4: For a read, `rd_fetch` is high in each cycle in which a read beat is issued. Exactly CAS-latency cycles later, `dq_oe` is high and `dq_col` carries that beat's column, so beat 0 appears CAS-latency cycles after the command.
- R5: When `dqm` is high in cycle t, `dq_oe` is low in cycle t+2, and the read beat due in that cycle is lost.
- R6: `dq_oe` is low whenever no read beat is due. A read issued in the cycle after the previous burst's last beat keeps `dq_oe` high with no gap.
- R7: A read or write issued while a burst is active ends the old burst. The new command's beat 0 is issued in that same cycle.
- R8: A precharge (`cmd` = 3) whose `cmd_bank` equals the bank of the active burst ends the burst, and no beat is issued in that cycle. A precharge to another bank has no effect.
- R9: Burst stop (`cmd` = 4) ends a full-page burst with no beat in that cycle. At any other burst length it is ignored.
- R10: A full-page burst steps through every column of the row and wraps from the top column to column 0 without ending.
- R11: `burst_done` is high in the cycle in which the last beat of a fixed-length burst is issued. A burst that is cut short, and a full-page burst, produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Capture burst length and CAS latency this cycle |
| mode_bl | input | 3 | Burst length code |
| mode_cl | input | CL_W | CAS latency in cycles |
| cmd | input | 3 | Command: 0 none, 1 read, 2 write, 3 precharge, 4 burst stop |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column of a read or write |
| dqm | input | 1 | Beat mask for this cycle |
| beat_col | output | COL_W | Column of the beat issued this cycle |
| rd_fetch | output | 1 | A read beat is issued this cycle |
| wr_en | output | 1 | Write the beat issued this cycle |
| dq_oe | output | 1 | Drive read data on the bus (low means high impedance) |
| dq_col | output | COL_W | Column of the read beat on the bus |
| burst_done | output | 1 | Last beat of a fixed-length burst issued |

## Verification
A corrupted beat counter or start register shows up at once on `beat_col`, within the burst it belongs to. It appears either as a column that leaves the aligned block or as a burst that runs one beat too long or too short, which moves `burst_done` by the same amount. A fault in the read delay line shows up only CAS-latency cycles after the issue, as `dq_oe` shifted or with a gap between back-to-back bursts. A stale mask stage moves a dropped read beat by one cycle. A wrong record of the burst's bank only shows when a precharge arrives. It either fails to stop the beats or stops a burst on another bank.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_PRE   = 3'd3,
    CMD_BSTOP = 3'd4
  } cmd_e;
endpackage

// File: rtl/sdr_mode_reg.sv
// Holds burst length (as a wrap mask) and CAS latency between loads.
module sdr_mode_reg #(
  parameter int COL_W = 8,
  parameter int CL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [2:0]       bl_code,
  input  logic [CL_W-1:0]  cl_code,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full,
  output logic [CL_W-1:0]  cl
);
  logic [COL_W-1:0] mask_d;
  logic             full_d;

  always_comb begin
    full_d = 1'b0;
    unique case (bl_code)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7: begin
        mask_d = '1;
        full_d = 1'b1;
      end
      default: mask_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_mask <= '0;
      full      <= 1'b0;
      cl        <= CL_W'(2);
    end else if (load) begin
      wrap_mask <= mask_d;
      full      <= full_d;
      cl        <= (cl_code == '0) ? CL_W'(1) : cl_code;
    end
  end
endmodule

// File: rtl/sdr_beat_gen.sv
// Issues one beat per cycle: column, direction, last-beat flag.
module sdr_beat_gen
  import sdr_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [COL_W-1:0]  wrap_mask,
  input  logic              full,
  output logic              beat_vld,
  output logic              beat_wr,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last,
  output logic              act,
  output logic [BANK_W-1:0] bank
);
  logic              act_q, wr_q;
  logic [COL_W-1:0]  base_q, cnt_q;
  logic [BANK_W-1:0] bank_q;

  logic             new_burst, cut;
  logic [COL_W-1:0] base, idx;

  always_comb begin
    new_burst = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    cut       = ((cmd == CMD_PRE) && (cmd_bank == bank_q)) ||
                ((cmd == CMD_BSTOP) && full);
    base      = new_burst ? cmd_col : base_q;
    idx       = new_burst ? '0 : cnt_q;
    beat_vld  = new_burst || (act_q && !cut);
    beat_wr   = new_burst ? (cmd == CMD_WRITE) : wr_q;
    beat_col  = (base & ~wrap_mask) | ((base + idx) & wrap_mask);
    beat_last = beat_vld && !full && (idx == wrap_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else if (beat_vld) begin
      act_q  <= !beat_last;
      wr_q   <= beat_wr;
      base_q <= base;
      cnt_q  <= idx + COL_W'(1);
      if (new_burst) bank_q <= cmd_bank;
    end else begin
      act_q <= 1'b0;
    end
  end

  assign act  = act_q;
  assign bank = bank_q;
endmodule

// File: rtl/sdr_read_pipe.sv
// Delays read beats by the CAS latency and applies the two-cycle read mask.
module sdr_read_pipe #(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [COL_W-1:0] col,
  input  logic [CL_W-1:0]  cl,
  input  logic             dqm,
  output logic             oe,
  output logic [COL_W-1:0] oe_col
);
  localparam int SW = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic [MAX_CL-1:0] vld_q;
  logic [COL_W-1:0]  col_q [MAX_CL];
  logic [1:0]        mask_q;
  logic [SW-1:0]     sel;

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vld_q[g] <= 1'b0;
        else     vld_q[g] <= issue;
        col_q[g] <= col;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) vld_q[g] <= 1'b0;
        else     vld_q[g] <= vld_q[g-1];
        col_q[g] <= col_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= {mask_q[0], dqm};
  end

  always_comb begin
    sel    = SW'(cl - CL_W'(1));
    oe     = vld_q[sel] && !mask_q[1];
    oe_col = col_q[sel];
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int MAX_CL = 3,
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [2:0]        mode_bl,
  input  logic [CL_W-1:0]   mode_cl,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              dqm,
  output logic [COL_W-1:0]  beat_col,
  output logic              rd_fetch,
  output logic              wr_en,
  output logic              dq_oe,
  output logic [COL_W-1:0]  dq_col,
  output logic              burst_done
);
  logic [COL_W-1:0]  wrap_mask;
  logic              full_pg;
  logic [CL_W-1:0]   cl_q;
  logic              beat_vld, beat_wr, beat_last;
  logic              burst_act;
  logic [BANK_W-1:0] burst_bank;

  sdr_mode_reg #(.COL_W(COL_W), .CL_W(CL_W)) u_mode (
    .clk(clk), .rst(rst), .load(mode_load), .bl_code(mode_bl),
    .cl_code(mode_cl), .wrap_mask(wrap_mask), .full(full_pg), .cl(cl_q)
  );

  sdr_beat_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_beat (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .wrap_mask(wrap_mask), .full(full_pg), .beat_vld(beat_vld),
    .beat_wr(beat_wr), .beat_col(beat_col), .beat_last(beat_last),
    .act(burst_act), .bank(burst_bank)
  );

  assign rd_fetch   = beat_vld && !beat_wr;
  assign wr_en      = beat_vld && beat_wr && !dqm;
  assign burst_done = beat_last;

  sdr_read_pipe #(.COL_W(COL_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_rpipe (
    .clk(clk), .rst(rst), .issue(rd_fetch), .col(beat_col), .cl(cl_q),
    .dqm(dqm), .oe(dq_oe), .oe_col(dq_col)
  );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk
  import sdr_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CL_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_load,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              dqm,
  input logic              rd_fetch,
  input logic              wr_en,
  input logic              dq_oe,
  input logic              burst_done,
  input logic              full_pg,
  input logic [CL_W-1:0]   cl_q,
  input logic              burst_act,
  input logic [BANK_W-1:0] burst_bank
);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_load |=> ($stable(cl_q) && $stable(full_pg)));

  // R3
  write_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WRITE) |-> (wr_en == !dqm));

  // R5
  read_mask_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !$past(dqm, 2));

  // R8
  pre_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && burst_act && cmd_bank == burst_bank) |-> !(wr_en || rd_fetch));

  // R10
  fullpage_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    full_pg |-> !burst_done);

  // R11
  done_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> (wr_en || rd_fetch || dqm));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.BANK_W(BANK_W), .CL_W(CL_W)) u_chk (
  .clk(clk), .rst(rst), .mode_load(mode_load), .cmd(cmd), .cmd_bank(cmd_bank),
  .dqm(dqm), .rd_fetch(rd_fetch), .wr_en(wr_en), .dq_oe(dq_oe),
  .burst_done(burst_done), .full_pg(full_pg), .cl_q(cl_q),
  .burst_act(burst_act), .burst_bank(burst_bank)
);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;
  import sdr_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_load = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic [1:0] mode_cl = 2'd2;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic [7:0] cmd_col = 8'd0;
  logic       dqm = 1'b0;
  logic [7:0] beat_col, dq_col;
  logic       rd_fetch, wr_en, dq_oe, burst_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sdram_burst_seq u_dut (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_bl(mode_bl),
    .mode_cl(mode_cl), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .dqm(dqm), .beat_col(beat_col), .rd_fetch(rd_fetch), .wr_en(wr_en),
    .dq_oe(dq_oe), .dq_col(dq_col), .burst_done(burst_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] c, input logic [1:0] b, input logic [7:0] col,
                      input logic m);
    @(negedge clk);
    mode_load = 1'b0;
    cmd = c;
    cmd_bank = b;
    cmd_col = col;
    dqm = m;
    #1;
  endtask

  task automatic set_mode(input logic [2:0] code, input logic [1:0] cl);
    @(negedge clk);
    cmd = CMD_NOP;
    dqm = 1'b0;
    mode_load = 1'b1;
    mode_bl = code;
    mode_cl = cl;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
  endtask

  function automatic int bl_of(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] ecol(input logic [7:0] s, input int bl, input int k);
    logic [7:0] m;
    m = 8'(bl - 1);
    return (s & ~m) | (8'(int'(s) + k) & m);
  endfunction

  // vector: [15] write, [14:12] length code, [11:10] CAS latency, [7:0] start column
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 3'd2, 2'd2, 2'd0, 8'd6},
    {1'b0, 3'd2, 2'd2, 2'd0, 8'd6},
    {1'b0, 3'd3, 2'd3, 2'd0, 8'd13},
    {1'b1, 3'd3, 2'd1, 2'd0, 8'd13},
    {1'b0, 3'd1, 2'd1, 2'd0, 8'd3},
    {1'b1, 3'd1, 2'd3, 2'd0, 8'd3},
    {1'b0, 3'd0, 2'd3, 2'd0, 8'd200},
    {1'b0, 3'd3, 2'd1, 2'd0, 8'd127}
  };

  task automatic run_vec(input logic [15:0] v);
    int bl, cl;
    bl = bl_of(v[14:12]);
    cl = int'(v[11:10]);
    set_mode(v[14:12], v[11:10]);
    for (int c = 0; c < bl + cl + 2; c++) begin
      tick((c == 0) ? (v[15] ? CMD_WRITE : CMD_READ) : CMD_NOP, 2'd0, v[7:0], 1'b0);
      if (v[15]) begin
        chk("R3 wr_en", 32'(wr_en), 32'(c < bl));
      end else begin
        chk("R4 rd_fetch", 32'(rd_fetch), 32'(c < bl));
        chk("R4/R6 dq_oe", 32'(dq_oe), 32'(c >= cl && c < cl + bl));
        if (c >= cl && c < cl + bl)
          chk("R4 dq_col", 32'(dq_col), 32'(ecol(v[7:0], bl, c - cl)));
      end
      if (c < bl) chk("R2 beat_col", 32'(beat_col), 32'(ecol(v[7:0], bl, c)));
      chk("R11 burst_done", 32'(burst_done), 32'(c == bl - 1));
    end
  endtask

  initial begin
    // reset state
    for (int i = 0; i < 3; i++) begin
      tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
      chk("reset wr_en", 32'(wr_en), 32'd0);
      chk("reset dq_oe", 32'(dq_oe), 32'd0);
      chk("reset rd_fetch", 32'(rd_fetch), 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 defaults after reset: one beat, CAS latency 2
    tick(CMD_READ, 2'd0, 8'd5, 1'b0);
    chk("R1 default fetch", 32'(rd_fetch), 32'd1);
    chk("R1 default done", 32'(burst_done), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 default fetch end", 32'(rd_fetch), 32'd0);
    chk("R1 default cl early", 32'(dq_oe), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 default cl oe", 32'(dq_oe), 32'd1);
    chk("R1 default cl col", 32'(dq_col), 32'd5);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 default oe end", 32'(dq_oe), 32'd0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R1 reserved length code gives one beat
    set_mode(3'd5, 2'd1);
    tick(CMD_WRITE, 2'd0, 8'd9, 1'b0);
    chk("R1 reserved wr", 32'(wr_en), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 reserved single", 32'(wr_en), 32'd0);

    // R1 mode input ignored without load
    set_mode(3'd2, 2'd2);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    mode_bl = 3'd3;
    tick(CMD_WRITE, 2'd0, 8'd0, 1'b0);
    for (int c = 1; c < 4; c++) tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 hold last", 32'(burst_done), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 hold stop", 32'(wr_en), 32'd0);

    // R1 CAS latency 0 taken as 1
    set_mode(3'd1, 2'd0);
    tick(CMD_READ, 2'd0, 8'd4, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R1 cl0 oe", 32'(dq_oe), 32'd1);
    chk("R1 cl0 col", 32'(dq_col), 32'd4);
    drain();

    // R3 write mask same cycle
    set_mode(3'd2, 2'd2);
    tick(CMD_WRITE, 2'd0, 8'd4, 1'b0);
    chk("R3 beat0", 32'(wr_en), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b1);
    chk("R3 masked", 32'(wr_en), 32'd0);
    chk("R3 masked col", 32'(beat_col), 32'd5);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R3 after mask", 32'(wr_en), 32'd1);
    chk("R3 after mask col", 32'(beat_col), 32'd6);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R3 last done", 32'(burst_done), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R3 ended", 32'(wr_en), 32'd0);

    // R5 read mask two cycles later
    tick(CMD_READ, 2'd0, 8'd8, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R5 beat0", 32'(dq_oe), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R5 masked", 32'(dq_oe), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R5 beat2", 32'(dq_oe), 32'd1);
    chk("R5 beat2 col", 32'(dq_col), 32'd10);
    drain();

    // R6 gapless back-to-back reads
    set_mode(3'd1, 2'd2);
    tick(CMD_READ, 2'd0, 8'd8, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    tick(CMD_READ, 2'd0, 8'd20, 1'b0);
    chk("R6 oe c2", 32'(dq_oe), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R6 oe c3", 32'(dq_col), 32'd9);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R6 oe c4", 32'(dq_oe), 32'd1);
    chk("R6 col c4", 32'(dq_col), 32'd20);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R6 col c5", 32'(dq_col), 32'd21);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R6 idle", 32'(dq_oe), 32'd0);

    // R7 read interrupts write
    set_mode(3'd3, 2'd1);
    tick(CMD_WRITE, 2'd0, 8'd0, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    tick(CMD_READ, 2'd0, 8'd16, 1'b0);
    chk("R7 no wr", 32'(wr_en), 32'd0);
    chk("R7 fetch", 32'(rd_fetch), 32'd1);
    chk("R7 col", 32'(beat_col), 32'd16);
    chk("R11 cut no done", 32'(burst_done), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R7 next col", 32'(beat_col), 32'd17);
    chk("R7 dq", 32'(dq_col), 32'd16);
    for (int i = 0; i < 12; i++) tick(CMD_NOP, 2'd0, 8'd0, 1'b0);

    // R8 precharge: other bank ignored, own bank cuts
    set_mode(3'd3, 2'd2);
    tick(CMD_READ, 2'd1, 8'd0, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    tick(CMD_PRE, 2'd0, 8'd0, 1'b0);
    chk("R8 other bank", 32'(rd_fetch), 32'd1);
    chk("R8 other bank col", 32'(beat_col), 32'd2);
    tick(CMD_PRE, 2'd1, 8'd0, 1'b0);
    chk("R8 cut", 32'(rd_fetch), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R8 stays idle", 32'(rd_fetch), 32'd0);
    chk("R8 last beat out", 32'(dq_col), 32'd2);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R8 oe ends", 32'(dq_oe), 32'd0);
    drain();

    // R9 burst stop ignored at fixed length
    set_mode(3'd2, 2'd2);
    tick(CMD_WRITE, 2'd0, 8'd0, 1'b0);
    tick(CMD_BSTOP, 2'd0, 8'd0, 1'b0);
    chk("R9 ignored", 32'(wr_en), 32'd1);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R9 runs out", 32'(burst_done), 32'd1);

    // R10 full page wraps, R9 stop honoured
    set_mode(3'd7, 2'd2);
    tick(CMD_WRITE, 2'd0, 8'd254, 1'b0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R10 col 255", 32'(beat_col), 32'd255);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R10 wrap 0", 32'(beat_col), 32'd0);
    chk("R10 no done", 32'(burst_done), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R10 col 1", 32'(beat_col), 32'd1);
    tick(CMD_BSTOP, 2'd0, 8'd0, 1'b0);
    chk("R9 full stop", 32'(wr_en), 32'd0);
    tick(CMD_NOP, 2'd0, 8'd0, 1'b0);
    chk("R9 full stopped", 32'(wr_en), 32'd0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule